// File: doc/BRIEF.md
# Dual-Compare Alternating PWM Timer

This block is an 8-bit up-counter that generates a variable-duty PWM waveform from two compare values. The counter advances only on a count tick, which comes from a free-running divider; a 3-bit select picks a tick rate of one tick every 2^s system clocks. Only one compare value is live at a time, and the block alternates between them.

The period compare (slot 0) closes each period. Its match clears the counter, emits a one-cycle interrupt pulse and drives the output active. The comparison then moves to the duty compare (slot 1). A duty match drives the output inactive and returns the comparison to slot 0. It neither clears the counter nor interrupts.

Software writes both compare values over a single-beat write port. A period value takes effect at once. A duty value enters a shadow copy and reaches the live compare only after three count ticks. Dropping the enable stops the block and invalidates the live duty value, so software must write it again before restarting.

Top module: `pwm_dual_cmp_timer`

## Requirements
- R1: In reset, and on every clock after a cycle with `enable` low, `pwmOut` and `irqPulse` are 0. The counter returns to 0 and the comparison returns to slot 0.
- R2: After `enable` rises, slot 0 is compared first. With slot 0 holding N and a tick on every clock, the first `irqPulse` is seen N+1 clocks after the first enabled edge.
- R3: A slot-0 match clears the counter, drives `pwmOut` to 1 and raises `irqPulse` for exactly one cycle, in the same cycle that `pwmOut` becomes 1.
- R4: A slot-1 match drives `pwmOut` to 0 and does not clear the counter or raise `irqPulse`. With slot 0 = N and slot 1 = M < N, the period is N+1 ticks, the active time is M+1 ticks and the inactive time is N−M ticks.
- R5: `prescSel` = s (0..7) gives one count tick every 2^s clocks. Between ticks, the counter, `pwmOut` and `irqPulse` do not advance.
- R6: A write to slot 1 (`wrSel`=1) is used for comparison only after three count ticks that follow the write edge. Until then, the previous duty value governs.
- R7: A falling `enable` invalidates the live duty value and cancels any pending transfer. Until a new slot-1 write completes its transfer, no slot-1 match occurs, so `pwmOut` stays 1 for whole periods after the first slot-0 match.
- R8: When M ≥ N, the counter still wraps on every slot-0 match, `irqPulse` fires every N+1 ticks and `pwmOut` stays 1 for the whole period. When M = N, the slot-0 match takes priority.
- R9: At any tick rate, `irqPulse` lasts one system clock per slot-0 match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Count enable; low stops and clears the timer |
| prescSel | input | 3 | Tick rate select: one tick every 2^prescSel clocks |
| wrEn | input | 1 | Compare write strobe |
| wrSel | input | 1 | Compare slot: 0 = period, 1 = duty |
| wrData | input | 8 | Compare value to write |
| pwmOut | output | 1 | PWM output, 1 = active |
| irqPulse | output | 1 | One-cycle pulse on each period match |

## Verification
The bench writes a duty value on the exact clock of a period wrap. A design with a shorter transfer, or none, would apply the new width inside the current period instead of the next. It restarts the timer without rewriting the duty value, where a design that kept the stale copy would produce the old duty cycle instead of a fully active period. It also runs M > N and M = N, where a design that compared only the duty slot after a wrap would miss the period match and run the counter through 255. A slow tick rate checks that the interrupt stays a single clock wide and does not stretch over a whole tick.

// File: rtl/pwm_dual_cmp_pkg.sv
package pwm_dual_cmp_pkg;
  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clrCnt;    // force counter to zero
    logic incCnt;    // advance counter by one
    logic dropCmp1;  // invalidate live duty compare and pending transfer
  } cnt_ctl_t;
endpackage

// File: rtl/pwm_dual_cmp_presc.sv
module pwm_dual_cmp_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NUM_RATES = 2 ** SEL_W;
  localparam int DIV_W     = NUM_RATES - 1;

  logic [DIV_W-1:0]     divCnt;
  logic [NUM_RATES-1:0] tickVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign tickVec[0] = 1'b1;
  for (genvar k = 1; k < NUM_RATES; k++) begin : gen_rate
    assign tickVec[k] = &divCnt[k-1:0];
  end

  assign tick = tickVec[sel];
endmodule

// File: rtl/pwm_dual_cmp_dp.sv
module pwm_dual_cmp_dp
  import pwm_dual_cmp_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int XFER_TICKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  cnt_ctl_t         ctl,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp0,
  output logic [CNT_W-1:0] cmp1Act,
  output logic             cmp1Valid
);
  localparam int PEND_W = $clog2(XFER_TICKS + 1);

  logic [CNT_W-1:0]  cmp1Shadow;
  logic [PEND_W-1:0] pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.clrCnt) begin
      cnt <= '0;
    end else if (ctl.incCnt) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmp0 <= '0;
    end else if (wrEn && !wrSel) begin
      cmp0 <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmp1Shadow <= '0;
      cmp1Act    <= '0;
      cmp1Valid  <= 1'b0;
      pend       <= '0;
    end else if (ctl.dropCmp1) begin
      cmp1Valid <= 1'b0;
      pend      <= '0;
    end else if (wrEn && wrSel) begin
      cmp1Shadow <= wrData;
      pend       <= PEND_W'(XFER_TICKS);
    end else if (tick && (pend != '0)) begin
      pend <= pend - 1'b1;
      if (pend == PEND_W'(1)) begin
        cmp1Act   <= cmp1Shadow;
        cmp1Valid <= 1'b1;
      end
    end
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrCnt |=> (cnt == '0)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clrCnt && !ctl.incCnt) |=> $stable(cnt)); // R5
  AST_XFER_LATE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmp1Act) |-> ($past(pend) == PEND_W'(1) && $past(tick))); // R6
  AST_DROP_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dropCmp1 |=> !cmp1Valid); // R7
endmodule

// File: rtl/pwm_dual_cmp_ctl.sv
module pwm_dual_cmp_ctl
  import pwm_dual_cmp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1Act,
  input  logic             cmp1Valid,
  output cnt_ctl_t         ctl,
  output logic             pwmOut,
  output logic             irqPulse
);
  logic ptrOne, ptrNext;
  logic outNext, irqNext;
  logic enPrev;
  logic hit0, hit1;

  always_comb begin
    hit0    = (cnt == cmp0);
    hit1    = cmp1Valid && (cnt == cmp1Act);
    ctl     = '0;
    ptrNext = ptrOne;
    outNext = pwmOut;
    irqNext = 1'b0;
    if (!enable) begin
      ctl.clrCnt = 1'b1;
      ptrNext    = 1'b0;
      outNext    = 1'b0;
    end else if (tick) begin
      if (hit0) begin
        // period match: wraps from either slot (slot 1 only when M >= N)
        ctl.clrCnt = 1'b1;
        irqNext    = 1'b1;
        outNext    = 1'b1;
        ptrNext    = 1'b1;
      end else if (ptrOne && hit1) begin
        ctl.incCnt = 1'b1;
        outNext    = 1'b0;
        ptrNext    = 1'b0;
      end else begin
        ctl.incCnt = 1'b1;
      end
    end
    ctl.dropCmp1 = enPrev && !enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrOne   <= 1'b0;
      pwmOut   <= 1'b0;
      irqPulse <= 1'b0;
      enPrev   <= 1'b0;
    end else begin
      ptrOne   <= ptrNext;
      pwmOut   <= outNext;
      irqPulse <= irqNext;
      enPrev   <= enable;
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!pwmOut && !irqPulse && !ptrOne)); // R1
  AST_IRQ_WITH_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> pwmOut); // R3
  AST_DUTY_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tick && ptrOne && hit1 && !hit0) |=> (!irqPulse && !pwmOut)); // R4
  AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tick) |=> (!irqPulse && pwmOut == $past(pwmOut))); // R5
  AST_WRAP_FROM_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tick && ptrOne && hit0) |=> (pwmOut && irqPulse)); // R8
endmodule

// File: rtl/pwm_dual_cmp_timer.sv
module pwm_dual_cmp_timer
  import pwm_dual_cmp_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SEL_W      = 3,
  parameter int XFER_TICKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] prescSel,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmOut,
  output logic             irqPulse
);
  logic             tick;
  cnt_ctl_t         ctl;
  logic [CNT_W-1:0] cnt, cmp0, cmp1Act;
  logic             cmp1Valid;

  pwm_dual_cmp_presc #(.SEL_W(SEL_W)) presc_i (
    .clk(clk), .rstN(rstN), .sel(prescSel), .tick(tick)
  );

  pwm_dual_cmp_dp #(.CNT_W(CNT_W), .XFER_TICKS(XFER_TICKS)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cnt(cnt), .cmp0(cmp0), .cmp1Act(cmp1Act), .cmp1Valid(cmp1Valid)
  );

  pwm_dual_cmp_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
    .cnt(cnt), .cmp0(cmp0), .cmp1Act(cmp1Act), .cmp1Valid(cmp1Valid),
    .ctl(ctl), .pwmOut(pwmOut), .irqPulse(irqPulse)
  );
endmodule

// File: tb/pwm_dual_cmp_timer_tb.sv
module pwm_dual_cmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] prescSel = 3'd0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       pwmOut, irqPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_cmp_timer dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .prescSel(prescSel),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .pwmOut(pwmOut), .irqPulse(irqPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic slot, input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = slot; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIrq(input int maxCyc, output int cyc);
    cyc = 0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      cyc++;
      if (irqPulse) return;
    end
    cyc = -1;
  endtask

  // Starts on a sample showing irqPulse; counts over one period, ends on the next period sample
  task automatic measure(input int period, output int highs, output int irqs, output bit nextIrq);
    highs = int'(pwmOut);
    irqs  = int'(irqPulse);
    for (int i = 1; i < period; i++) begin
      @(negedge clk);
      wrEn = 1'b0;
      highs += int'(pwmOut);
      irqs  += int'(irqPulse);
    end
    @(negedge clk);
    wrEn = 1'b0;
    nextIrq = irqPulse;
  endtask

  task automatic startTimer(input logic [2:0] sel, input logic [7:0] n, input logic [7:0] m);
    @(negedge clk);
    enable = 1'b0; prescSel = sel;
    wrReg(1'b0, n);
    wrReg(1'b1, m);
    repeat (8 * (1 << sel)) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic t_reset();
    check(pwmOut == 1'b0, "R1 reset pwmOut", int'(pwmOut), 0);
    check(irqPulse == 1'b0, "R1 reset irqPulse", int'(irqPulse), 0);
  endtask

  task automatic t_basic();
    int cyc, highs, irqs; bit nxt;
    startTimer(3'd0, 8'd9, 8'd3);
    waitIrq(100, cyc);
    check(cyc == 10, "R2 first period latency", cyc, 10);
    check(pwmOut == 1'b1, "R3 active with irq", int'(pwmOut), 1);
    measure(10, highs, irqs, nxt);
    check(highs == 4, "R4 active width M+1", highs, 4);
    check(irqs == 1, "R3 single irq per period", irqs, 1);
    check(nxt == 1'b1, "R4 period N+1", int'(nxt), 1);
  endtask

  task automatic t_delay();
    int highs, irqs; bit nxt;
    // on a wrap sample: write new duty, captured at next edge
    wrEn = 1'b1; wrSel = 1'b1; wrData = 8'd6;
    measure(10, highs, irqs, nxt);
    check(highs == 4, "R6 old duty during transfer", highs, 4);
    measure(10, highs, irqs, nxt);
    check(highs == 7, "R6 new duty after transfer", highs, 7);
    check(nxt == 1'b1, "R6 period unchanged", int'(nxt), 1);
  endtask

  task automatic t_stale();
    int cyc, highs, irqs; bit nxt;
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0, "R1 disabled pwmOut", int'(pwmOut), 0);
    check(irqPulse == 1'b0, "R1 disabled irqPulse", int'(irqPulse), 0);
    enable = 1'b1;
    waitIrq(100, cyc);
    check(cyc == 10, "R7 counter cleared by disable", cyc, 10);
    measure(10, highs, irqs, nxt);
    check(highs == 10, "R7 stale duty unused", highs, 10);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 8'd3;
    measure(10, highs, irqs, nxt);
    measure(10, highs, irqs, nxt);
    check(highs == 4, "R7 rewritten duty used", highs, 4);
  endtask

  task automatic t_prescale();
    int cyc, highs, irqs; bit nxt;
    startTimer(3'd2, 8'd20, 8'd5);
    waitIrq(1000, cyc);
    check(cyc > 0, "R5 irq at slow rate", cyc, 1);
    measure(84, highs, irqs, nxt);
    check(highs == 24, "R5 active width scaled", highs, 24);
    check(irqs == 1, "R9 irq one clock wide", irqs, 1);
    check(nxt == 1'b1, "R5 period scaled", int'(nxt), 1);
  endtask

  task automatic t_degenerate();
    int cyc, highs, irqs; bit nxt;
    startTimer(3'd0, 8'd5, 8'd7);
    waitIrq(100, cyc);
    check(cyc == 6, "R8 wrap with M>N", cyc, 6);
    measure(6, highs, irqs, nxt);
    check(highs == 6, "R8 fully active M>N", highs, 6);
    check(nxt == 1'b1, "R8 period N+1 M>N", int'(nxt), 1);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 8'd5;
    measure(6, highs, irqs, nxt);
    measure(6, highs, irqs, nxt);
    check(highs == 6, "R8 fully active M=N", highs, 6);
    check(irqs == 1 && nxt, "R8 irq each period M=N", irqs, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_delay();
    t_stale();
    t_prescale();
    t_degenerate();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule